// File: doc/BRIEF.md
# Synchronized Clock-Enable Fanout Gate

This block picks one of two incoming clocks with a static source select. It gates the picked clock with an enable that may change at any time, and copies the gated clock onto a set of true and complement output pairs. The enable is retimed to the picked clock before it reaches the gate. The gate therefore opens or closes only while the clock is low, and no output ever shows a shortened high phase.

The enable is taken on a rising edge of the picked clock and handed to the gate on the following falling edge. When the gate is closed, every true output rests low and every complement output rests high. An active-low asynchronous reset closes the gate at once. Changing the source select is a configuration step: close the gate first, then switch the select, and wait a few cycles of the new clock before opening the gate again.

Top module: `cgf_gate_top`

## Requirements
- R1: Source select value 0 drives the outputs from `clk_in_a`, and value 1 drives them from `clk_in_b`.
- R2: While the gate is open, each true output equals the level of the selected clock.
- R3: While the gate is closed, every true output is 0 and every complement output is 1.
- R4: Each complement output is at all times the inverse of its true output.
- R5: The level of `gate_en_async` just before rising edge k of the selected clock decides the gate state for the high phase that starts at rising edge k+1. The gate state changes on the falling edge between those two rising edges.
- R6: A true output is never high while the selected clock is low. Every true-output high pulse rises with a rising edge of the selected clock, falls with the next falling edge, and lasts exactly one high phase of that clock.
- R7: All output pairs carry the same value at all times.
- R8: While `rst_n` is 0, the outputs take the closed levels at once, whatever the clock phase. After release with the enable high, the first open high phase is the one that starts at the second rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in_a | input | 1 | First source clock, picked when the select is 0 |
| clk_in_b | input | 1 | Second source clock, picked when the select is 1 |
| src_sel | input | 1 | Static source select |
| gate_en_async | input | 1 | Output enable, may change at any time |
| rst_n | input | 1 | Active-low asynchronous reset, closes the gate |
| ck_out | output | PAIRS | True clock outputs |
| ck_out_b | output | PAIRS | Complement clock outputs |

## Verification
The properties are clocked on the selected clock, so they rely on the select staying still while the gate is open. They also rely on reset edges that never fall exactly on a clock edge. The stimulus closes the gate and waits three cycles before every select change, and it waits three cycles of the new clock before opening the gate again. The enable is moved at several offsets inside the clock period, including offsets inside the high phase and inside the low phase. Reset is asserted in the middle of a high phase and released just after a falling edge, away from any edge.

// File: rtl/cgf_pkg.sv
package cgf_pkg;
  // number of complementary output pairs driven by the gate
  parameter int unsigned CGF_PAIRS = 4;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } cgf_src_e;
endpackage

// File: rtl/cgf_src_mux.sv
module cgf_src_mux
  import cgf_pkg::*;
(
  input  logic clk_a,
  input  logic clk_b,
  input  logic sel,
  output logic clk_o
);
  cgf_src_e src;

  always_comb begin
    src   = cgf_src_e'(sel);
    clk_o = (src == SRC_B) ? clk_b : clk_a;
  end
endmodule

// File: rtl/cgf_en_sync.sv
module cgf_en_sync (
  input  logic ck,
  input  logic rst_n,
  input  logic en_async,
  output logic gate_open
);
  logic en_cap;

  // capture on the rising edge of the selected clock
  always_ff @(posedge ck or negedge rst_n) begin
    if (!rst_n) en_cap <= 1'b0;
    else        en_cap <= en_async;
  end

  // hand over on the falling edge, so the gate moves only while ck is low
  always_ff @(negedge ck or negedge rst_n) begin
    if (!rst_n) gate_open <= 1'b0;
    else        gate_open <= en_cap;
  end
endmodule

// File: rtl/cgf_fanout.sv
module cgf_fanout #(
  parameter int unsigned PAIRS = 4
) (
  input  logic             ck,
  input  logic             gate_open,
  output logic [PAIRS-1:0] q,
  output logic [PAIRS-1:0] q_b
);
  logic gated;

  assign gated = ck & gate_open;

  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    assign q[i]   = gated;
    assign q_b[i] = ~gated;
  end
endmodule

// File: rtl/cgf_gate_top.sv
module cgf_gate_top
  import cgf_pkg::*;
#(
  parameter int unsigned PAIRS = CGF_PAIRS
) (
  input  logic             clk_in_a,
  input  logic             clk_in_b,
  input  logic             src_sel,
  input  logic             gate_en_async,
  input  logic             rst_n,
  output logic [PAIRS-1:0] ck_out,
  output logic [PAIRS-1:0] ck_out_b
);
  logic sel_ck;
  logic gate_open;

  cgf_src_mux u_mux (
    .clk_a (clk_in_a),
    .clk_b (clk_in_b),
    .sel   (src_sel),
    .clk_o (sel_ck)
  );

  cgf_en_sync u_sync (
    .ck        (sel_ck),
    .rst_n     (rst_n),
    .en_async  (gate_en_async),
    .gate_open (gate_open)
  );

  cgf_fanout #(.PAIRS(PAIRS)) u_fan (
    .ck        (sel_ck),
    .gate_open (gate_open),
    .q         (ck_out),
    .q_b       (ck_out_b)
  );
endmodule

// File: rtl/cgf_gate_chk.sv
module cgf_gate_chk #(
  parameter int unsigned PAIRS = 4
) (
  input logic             clk_in_a,
  input logic             clk_in_b,
  input logic             src_sel,
  input logic             gate_en_async,
  input logic             rst_n,
  input logic [PAIRS-1:0] ck_out,
  input logic [PAIRS-1:0] ck_out_b
);
  logic ck;
  logic en_seen;

  assign ck = src_sel ? clk_in_b : clk_in_a;

  // enable level observed at each rising edge of the selected clock
  always_ff @(posedge ck or negedge rst_n) begin
    if (!rst_n) en_seen <= 1'b0;
    else        en_seen <= gate_en_async;
  end

  AST_PAIR_INVERSE_HI: assert property (@(negedge ck) disable iff (!rst_n)
    ck_out_b == ~ck_out); // R4
  AST_PAIR_INVERSE_LO: assert property (@(posedge ck) disable iff (!rst_n)
    ck_out_b == ~ck_out); // R4
  AST_LOW_WHILE_CLK_LOW: assert property (@(posedge ck) disable iff (!rst_n)
    ck_out == '0); // R6
  AST_PAIRS_AGREE: assert property (@(negedge ck) disable iff (!rst_n)
    (ck_out == '0) || (ck_out == '1)); // R7
  AST_ENABLE_LATENCY: assert property (@(negedge ck) disable iff (!rst_n)
    ck_out == {PAIRS{$past(en_seen)}}); // R5
  AST_RESET_CLOSED: assert property (@(negedge ck)
    !rst_n |-> (ck_out == '0 && ck_out_b == '1)); // R8
endmodule

bind cgf_gate_top cgf_gate_chk #(.PAIRS(PAIRS)) u_chk (
  .clk_in_a      (clk_in_a),
  .clk_in_b      (clk_in_b),
  .src_sel       (src_sel),
  .gate_en_async (gate_en_async),
  .rst_n         (rst_n),
  .ck_out        (ck_out),
  .ck_out_b      (ck_out_b)
);

// File: tb/cgf_gate_top_tb.sv
`timescale 1ns/1ps
module cgf_gate_top_tb_top;
  localparam int N = 4;

  logic clk_in_a = 1'b0;
  logic clk_in_b = 1'b0;
  logic src_sel, gate_en_async, rst_n;
  logic [N-1:0] ck_out, ck_out_b;
  logic ref_ck;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  realtime mon_start = 0.0;
  realtime t_rise = 0.0;
  logic cur_en;

  always #5 clk_in_a = ~clk_in_a;   // 100 MHz
  always #7 clk_in_b = ~clk_in_b;

  assign ref_ck = src_sel ? clk_in_b : clk_in_a;

  cgf_gate_top dut_i (
    .clk_in_a      (clk_in_a),
    .clk_in_b      (clk_in_b),
    .src_sel       (src_sel),
    .gate_en_async (gate_en_async),
    .rst_n         (rst_n),
    .ck_out        (ck_out),
    .ck_out_b      (ck_out_b)
  );

  // vector: select, enable, offset after a rising edge (ns), expected open
  typedef struct packed {
    logic       sel;
    logic       en;
    logic [3:0] off;
    logic       exp;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b0, 1'b1, 4'd1, 1'b1},
    '{1'b0, 1'b0, 4'd7, 1'b0},
    '{1'b0, 1'b1, 4'd4, 1'b1},
    '{1'b0, 1'b0, 4'd9, 1'b0},
    '{1'b1, 1'b1, 4'd2, 1'b1},
    '{1'b1, 1'b0, 4'd12, 1'b0},
    '{1'b1, 1'b1, 4'd8, 1'b1},
    '{1'b0, 1'b1, 4'd3, 1'b1},
    '{1'b0, 1'b0, 4'd6, 1'b0},
    '{1'b1, 1'b0, 4'd5, 1'b0}
  };

  task automatic chk(input bit ok, input string req,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic realtime qtr();
    return src_sel ? 3.5 : 2.5;
  endfunction

  // one high phase then one low phase of the selected clock
  task automatic sample_cycle(input logic exp_hi);
    logic [N-1:0] e;
    e = {N{exp_hi}};
    @(posedge ref_ck);
    #(qtr());
    // R7: all pairs carry the same value; R4: complements inverse
    chk(ck_out == e && ck_out_b == ~e, exp_hi ? "R2" : "R3",
        {ck_out_b, ck_out}, {~e, e});
    @(negedge ref_ck);
    #(qtr());
    chk(ck_out == '0 && ck_out_b == '1, "R6", {ck_out_b, ck_out}, {4'hF, 4'h0});
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge ref_ck);
  endtask

  // R6 / R1 monitor: pulse edges line up with the selected clock
  initial forever begin
    @(posedge ck_out[0]);
    t_rise = $realtime;
    #1;
    if (mon_on) chk(ref_ck === 1'b1, "R6", {7'd0, ref_ck}, 8'd1);
  end

  initial forever begin
    realtime w;
    @(negedge ck_out[0]);
    w = $realtime - t_rise;
    #1;
    if (mon_on && t_rise > mon_start) begin
      chk(ref_ck === 1'b0, "R6", {7'd0, ref_ck}, 8'd0);
      // R1: width identifies which clock drives the outputs
      chk((w > (2.0 * qtr()) - 0.01) && (w < (2.0 * qtr()) + 0.01), "R1",
          8'(int'(w)), 8'(int'(2.0 * qtr())));
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    src_sel = 1'b0;
    gate_en_async = 1'b0;
    cur_en = 1'b0;
    #23;
    chk(ck_out == '0 && ck_out_b == '1, "R8", {ck_out_b, ck_out}, {4'hF, 4'h0});
    #4 rst_n = 1'b1;
    wait_cycles(3);

    // table walk
    for (int v = 0; v < 10; v++) begin
      if (VEC[v].sel != src_sel) begin
        mon_on = 1'b0;
        gate_en_async = 1'b0;
        cur_en = 1'b0;
        wait_cycles(3);
        src_sel = VEC[v].sel;
        wait_cycles(3);
      end
      mon_on = 1'b1;
      mon_start = $realtime;
      @(posedge ref_ck);
      #(real'(VEC[v].off));
      gate_en_async = VEC[v].en;
      // R5: the next high phase keeps the old state, the one after takes the new
      sample_cycle(cur_en);
      sample_cycle(VEC[v].exp);
      sample_cycle(VEC[v].exp);
      cur_en = VEC[v].en;
    end

    // reset in the middle of an open high phase
    mon_on = 1'b0;
    gate_en_async = 1'b0;
    wait_cycles(3);
    src_sel = 1'b0;
    wait_cycles(3);
    gate_en_async = 1'b1;
    wait_cycles(3);
    @(posedge ref_ck);
    #2;
    chk(ck_out == '1, "R2", {4'h0, ck_out}, 8'h0F);
    rst_n = 1'b0;
    #1;
    chk(ck_out == '0 && ck_out_b == '1, "R8", {ck_out_b, ck_out}, {4'hF, 4'h0});
    sample_cycle(1'b0);
    @(negedge ref_ck);
    #1 rst_n = 1'b1;
    sample_cycle(1'b0);   // R8: first high after release stays closed
    sample_cycle(1'b1);   // R8: second one is open

    // R6: enable dropped inside a high phase does not cut it short
    mon_on = 1'b1;
    mon_start = $realtime;
    @(posedge ref_ck);
    #1 gate_en_async = 1'b0;
    sample_cycle(1'b1);
    sample_cycle(1'b0);
    mon_on = 1'b0;

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule